// File: doc/BRIEF.md
# Microsecond Event Timer Bank

This block holds four down-counting event timers. They share one register window and all advance on an externally supplied microsecond strobe. Each timer has two registers. The load register carries an enable flag, a periodic-reload flag and a 29-bit terminal count. The status register returns the live count and a pending flag, and a write of its clear bit acknowledges that flag. When a timer that is running sees a strobe with its count already at zero, it expires. An expiry sets a level-high interrupt line. A one-shot timer then disables itself. A periodic timer reloads its terminal count and keeps going.

Software asks for an N-tick delay by writing N-1 with the enable flag set. A repeating event every P ticks comes from writing the count P-1 with both flags set. Writing zero to the load register halts a timer.

Top module: `utmr_bank`

## Requirements
- R1: After reset every interrupt line is low and every register reads zero.
- R2: Timer k (k = 0..3) has its load register at byte offset 0x00, 0x08, 0x50 or 0x58 and its status register at that offset plus 4. A write to any other address changes nothing, and a read of any other address returns zero.
- R3: A load-register write stores bit 31 as enable, bit 30 as periodic and bits [28:0] as the terminal count, and copies the count into the counter. Reading the load register returns {enable, periodic, 0, count}, so bit 29 always reads 0.
- R4: A one-shot timer loaded with value V raises its interrupt in the cycle after the (V+1)-th strobe. At that expiry its enable bit clears and its counter stays at zero.
- R5: A periodic timer reloads its terminal count at each expiry and expires again after every further V+1 strobes.
- R6: The interrupt stays high until a status-register write with bit 30 set. A status write with bit 30 clear has no effect.
- R7: If a clear write and an expiry of the same timer fall in the same cycle, the interrupt stays pending.
- R8: After a load-register write of zero the counter no longer changes and no new interrupt is raised.
- R9: Without a strobe, the counter of an enabled timer holds its value.
- R10: A strobe in the same cycle as a load-register write is ignored by that timer, so counting restarts from the next strobe.
- R11: Reading the status register returns the counter in bits [28:0] and the pending flag in bit 30, with all other bits zero.
- R12: The four timers are independent. A write or an expiry of one timer leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | Microsecond strobe, one clock per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |
| irq | output | 4 | Level-high expiry interrupt per timer |

## Verification
The assertions assume that the inputs are known after reset, that at most one register is written per cycle, and that the strobe is sampled only at the clock edge. The stimulus keeps to these rules. All inputs are driven at the falling edge, and there is a single write port, so no two registers can be written in one cycle. Writes use addresses from the map plus one unmapped address. Terminal counts are kept small, so expiries, reloads and clear-versus-expiry collisions happen often during the random phase.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int CNT_W   = 29;
    localparam int N_TMR   = 4;
    localparam int BIT_EN  = 31;
    localparam int BIT_PER = 30;
    localparam int BIT_CLR = 30;
    localparam int BIT_PND = 30;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] PAIR_STEP = 8'h50;
    localparam logic [ADDR_W-1:0] MEMB_STEP = 8'h08;

    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } chan_st_t;

    // timers come in pairs: pair stride 0x50, member stride 0x08
    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        logic [ADDR_W-1:0] pair_ofs;
        logic [ADDR_W-1:0] memb_ofs;
        pair_ofs = ((idx / 2) != 0) ? PAIR_STEP : '0;
        memb_ofs = ((idx % 2) != 0) ? MEMB_STEP : '0;
        return pair_ofs + memb_ofs;
    endfunction
endpackage

// File: rtl/utmr_decode.sv
module utmr_decode
    import utmr_pkg::*;
#(
    parameter int NT = N_TMR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NT-1:0]        load_wr,
    output logic [NT-1:0]        stat_wr,
    output logic [NT-1:0]        load_rd,
    output logic [NT-1:0]        stat_rd
);
    for (genvar i = 0; i < NT; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] BASE = chan_base(i);
        always_comb begin
            load_wr[i] = wr_en && (wr_addr == BASE);
            stat_wr[i] = wr_en && (wr_addr == BASE + OFS_STAT);
            load_rd[i] = (rd_addr == BASE);
            stat_rd[i] = (rd_addr == BASE + OFS_STAT);
        end
    end

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_wr, stat_wr})); // R2
    AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_rd, stat_rd})); // R2
endmodule

// File: rtl/utmr_chan.sv
module utmr_chan
    import utmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              load_wr,
    input  logic              stat_wr,
    input  logic              w_en,
    input  logic              w_per,
    input  logic              w_clr,
    input  logic [CNT_W-1:0]  w_cnt,
    output logic [DATA_W-1:0] load_view,
    output logic [DATA_W-1:0] stat_view,
    output logic              irq
);
    chan_st_t st_d, st_q;
    logic     expire;
    logic     clr_req;

    always_comb begin
        st_d    = st_q;
        expire  = 1'b0;
        clr_req = stat_wr && w_clr;
        if (load_wr) begin
            st_d.en   = w_en;
            st_d.per  = w_per;
            st_d.load = w_cnt;
            st_d.cnt  = w_cnt;
        end else if (us_tick && st_q.en) begin
            if (st_q.cnt == '0) begin
                expire = 1'b1;
                if (st_q.per) begin
                    st_d.cnt = st_q.load;
                end else begin
                    st_d.en = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (expire) begin
            st_d.pend = 1'b1;
        end else if (clr_req) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        load_view = '0;
        load_view[BIT_EN]     = st_q.en;
        load_view[BIT_PER]    = st_q.per;
        load_view[CNT_W-1:0]  = st_q.load;
        stat_view = '0;
        stat_view[BIT_PND]    = st_q.pend;
        stat_view[CNT_W-1:0]  = st_q.cnt;
    end

    assign irq = st_q.pend;

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !(stat_wr && w_clr)) |=> st_q.pend); // R6
    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && us_tick && st_q.en && st_q.cnt == '0) |=> st_q.pend); // R7
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && us_tick && st_q.en && !st_q.per && st_q.cnt == '0)
        |=> (!st_q.en && st_q.cnt == '0)); // R4
    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && us_tick && st_q.en && st_q.per && st_q.cnt == '0)
        |=> (st_q.en && st_q.cnt == $past(st_q.load))); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && !us_tick) |=> $stable(st_q.cnt)); // R9
    AST_IDLE_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr && !st_q.en && !st_q.pend) |=> !st_q.pend); // R8
endmodule

// File: rtl/utmr_rdmux.sv
module utmr_rdmux
    import utmr_pkg::*;
#(
    parameter int NT = N_TMR
) (
    input  logic [NT-1:0]             load_rd,
    input  logic [NT-1:0]             stat_rd,
    input  logic [NT-1:0][DATA_W-1:0] load_view,
    input  logic [NT-1:0][DATA_W-1:0] stat_view,
    output logic [DATA_W-1:0]         rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NT; i++) begin
            if (load_rd[i]) rd_data = rd_data | load_view[i];
            if (stat_rd[i]) rd_data = rd_data | stat_view[i];
        end
    end
endmodule

// File: rtl/utmr_bank.sv
module utmr_bank
    import utmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [3:0]        irq
);
    logic [N_TMR-1:0]             load_wr, stat_wr, load_rd, stat_rd;
    logic [N_TMR-1:0][DATA_W-1:0] load_view, stat_view;
    logic                         unused_bit29;

    assign unused_bit29 = wr_data[29];

    utmr_decode #(.NT(N_TMR)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .load_wr (load_wr),
        .stat_wr (stat_wr),
        .load_rd (load_rd),
        .stat_rd (stat_rd)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_chan
        utmr_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .us_tick   (us_tick),
            .load_wr   (load_wr[i]),
            .stat_wr   (stat_wr[i]),
            .w_en      (wr_data[BIT_EN]),
            .w_per     (wr_data[BIT_PER]),
            .w_clr     (wr_data[BIT_CLR]),
            .w_cnt     (wr_data[CNT_W-1:0]),
            .load_view (load_view[i]),
            .stat_view (stat_view[i]),
            .irq       (irq[i])
        );
    end

    utmr_rdmux #(.NT(N_TMR)) u_rd (
        .load_rd   (load_rd),
        .stat_rd   (stat_rd),
        .load_view (load_view),
        .stat_view (stat_view),
        .rd_data   (rd_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0)); // R1
endmodule

// File: tb/utmr_bank_bench.sv
module utmr_bank_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    int base [4] = '{32'h00, 32'h08, 32'h50, 32'h58};
    int m_en [4], m_per [4], m_load [4], m_cnt [4], m_pend [4];

    always #(PERIOD/2) clk = ~clk;

    utmr_bank u_utmr_bank (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) begin
            if (int'(a) == base[i]) begin
                v[31] = m_en[i][0]; v[30] = m_per[i][0]; v[28:0] = m_load[i][28:0];
            end
            if (int'(a) == base[i] + 4) begin
                v[30] = m_pend[i][0]; v[28:0] = m_cnt[i][28:0];
            end
        end
        return v;
    endfunction

    task automatic m_update();
        for (int i = 0; i < 4; i++) begin
            bit lw = wr_en && int'(wr_addr) == base[i];
            bit cw = wr_en && int'(wr_addr) == base[i] + 4 && wr_data[30];
            bit ex = 0;
            if (lw) begin
                m_en[i] = wr_data[31]; m_per[i] = wr_data[30];
                m_load[i] = int'(wr_data[28:0]); m_cnt[i] = m_load[i];
            end else if (us_tick && m_en[i] != 0) begin
                if (m_cnt[i] == 0) begin
                    ex = 1;
                    if (m_per[i] != 0) m_cnt[i] = m_load[i];
                    else m_en[i] = 0;
                end else m_cnt[i]--;
            end
            if (ex) m_pend[i] = 1;
            else if (cw) m_pend[i] = 0;
        end
    endtask

    task automatic compare();
        logic [3:0] ei;
        for (int i = 0; i < 4; i++) ei[i] = m_pend[i][0];
        chk(irq === ei, {cur_req, " irq"}, {28'd0, irq}, {28'd0, ei});
        chk(rd_data === m_read(rd_addr), {cur_req, " rd"}, rd_data, m_read(rd_addr));
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare();
    endtask

    task automatic drv(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit t, input logic [7:0] ra);
        wr_en = w; wr_addr = a; wr_data = d; us_tick = t; rd_addr = ra;
    endtask

    task automatic idle(input bit t, input logic [7:0] ra, input int n);
        for (int k = 0; k < n; k++) begin
            drv(0, 8'h00, '0, t, ra);
            step();
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_per[i] = 0; m_load[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(irq === 4'h0, "R1", {28'd0, irq}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 8'(base[a]);     #1; chk(rd_data === 32'd0, "R1", rd_data, 32'd0);
            rd_addr = 8'(base[a] + 4); #1; chk(rd_data === 32'd0, "R1", rd_data, 32'd0);
        end

        // R3 field packing, bit 29 dropped
        cur_req = "R3";
        drv(1, 8'h50, 32'h3FFF_FFFF, 0, 8'h50); step();
        chk(rd_data === 32'h1FFF_FFFF, "R3", rd_data, 32'h1FFF_FFFF);
        drv(1, 8'h50, 32'hE000_0007, 0, 8'h50); step();
        chk(rd_data === 32'hC000_0007, "R3", rd_data, 32'hC000_0007);
        drv(1, 8'h50, 32'h0, 0, 8'h54); step();

        // R2 unmapped write ignored, reads zero
        cur_req = "R2";
        drv(1, 8'h10, 32'hC000_0003, 1, 8'h10); step();
        chk(rd_data === 32'd0, "R2", rd_data, 32'd0);
        chk(irq === 4'h0, "R2", {28'd0, irq}, 32'd0);
        drv(1, 8'h58, 32'h8000_0009, 0, 8'h58); step();
        chk(rd_data === 32'h8000_0009, "R2", rd_data, 32'h8000_0009);
        drv(1, 8'h58, 32'h0, 0, 8'h5C); step();

        // R4 one-shot, V=3 -> irq after 4th tick
        cur_req = "R4";
        drv(1, 8'h00, 32'h8000_0003, 0, 8'h00); step();
        idle(1, 8'h00, 3);
        chk(irq[0] === 1'b0, "R4", {31'd0, irq[0]}, 32'd0);
        idle(1, 8'h00, 1);
        chk(irq[0] === 1'b1, "R4", {31'd0, irq[0]}, 32'd1);
        chk(rd_data === 32'h0000_0003, "R4", rd_data, 32'h0000_0003);
        idle(1, 8'h04, 2);
        // R11 status layout
        chk(rd_data === 32'h4000_0000, "R11", rd_data, 32'h4000_0000);

        // R6 clear semantics
        cur_req = "R6";
        drv(1, 8'h04, 32'hBFFF_FFFF, 0, 8'h04); step();
        chk(irq[0] === 1'b1, "R6", {31'd0, irq[0]}, 32'd1);
        drv(1, 8'h04, 32'h4000_0000, 0, 8'h04); step();
        chk(irq[0] === 1'b0, "R6", {31'd0, irq[0]}, 32'd0);

        // R5 periodic V=1 -> every 2 ticks
        cur_req = "R5";
        drv(1, 8'h08, 32'hC000_0001, 0, 8'h0C); step();
        idle(1, 8'h0C, 2);
        chk(irq[1] === 1'b1, "R5", {31'd0, irq[1]}, 32'd1);
        chk(rd_data === 32'h4000_0001, "R5", rd_data, 32'h4000_0001);
        drv(1, 8'h0C, 32'h4000_0000, 1, 8'h0C); step();
        chk(irq[1] === 1'b0, "R5", {31'd0, irq[1]}, 32'd0);
        idle(1, 8'h0C, 1);
        chk(irq[1] === 1'b1, "R5", {31'd0, irq[1]}, 32'd1);

        // R8 stop by writing zero
        cur_req = "R8";
        drv(1, 8'h08, 32'h0, 1, 8'h0C); step();
        drv(1, 8'h0C, 32'h4000_0000, 1, 8'h0C); step();
        idle(1, 8'h0C, 10);
        chk(irq[1] === 1'b0, "R8", {31'd0, irq[1]}, 32'd0);
        chk(rd_data === 32'd0, "R8", rd_data, 32'd0);

        // R9 hold without tick
        cur_req = "R9";
        drv(1, 8'h50, 32'h8000_0005, 0, 8'h54); step();
        idle(0, 8'h54, 5);
        chk(rd_data === 32'h0000_0005, "R9", rd_data, 32'h0000_0005);

        // R10 tick coinciding with load is ignored
        cur_req = "R10";
        drv(1, 8'h50, 32'h8000_0002, 1, 8'h54); step();
        chk(rd_data === 32'h0000_0002, "R10", rd_data, 32'h0000_0002);
        idle(1, 8'h54, 1);
        chk(rd_data === 32'h0000_0001, "R10", rd_data, 32'h0000_0001);
        drv(1, 8'h50, 32'h0, 0, 8'h54); step();

        // R7 clear colliding with expiry
        cur_req = "R7";
        drv(1, 8'h58, 32'h8000_0000, 0, 8'h5C); step();
        idle(1, 8'h5C, 1);
        chk(irq[3] === 1'b1, "R7", {31'd0, irq[3]}, 32'd1);
        drv(1, 8'h58, 32'h8000_0000, 0, 8'h5C); step();
        drv(1, 8'h5C, 32'h4000_0000, 1, 8'h5C); step();
        chk(irq[3] === 1'b1, "R7", {31'd0, irq[3]}, 32'd1);
        drv(1, 8'h5C, 32'h4000_0000, 0, 8'h5C); step();
        chk(irq[3] === 1'b0, "R7", {31'd0, irq[3]}, 32'd0);

        // R12 random mix, model compared every cycle
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int pick = int'($urandom_range(0, 8));
            a = (pick == 8) ? 8'h10 : 8'(base[pick / 2] + 4 * (pick % 2));
            d = {$urandom()} & 32'hE000_0000;
            d[2:0] = 3'($urandom_range(0, 6));
            drv(($urandom_range(0, 9) < 3), a, d, ($urandom_range(0, 1) == 1),
                8'(base[$urandom_range(0, 3)] + 4 * int'($urandom_range(0, 1))));
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule